// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer with Standby Control

This block decides when an external temperature converter runs and what happens to its results. It drives a start/done/result handshake for two channels, a local one and a remote one. In normal operation it converts the local channel, waits a programmable number of cycles, converts the remote channel, waits again, and repeats. Each completed result is written into the value register for its channel.

Two standby sources stop this cycle, and they behave differently. Hardware standby (`stby_n` low) blocks every conversion, including one-shot requests. Software standby (`sw_stby` high, with `stby_n` high) stops the periodic cycle but still accepts a one-shot request. A one-shot converts the local channel and then the remote channel back to back, and the block then returns to standby. Entering either standby during a conversion ends that conversion at once, and its result is thrown away.

The open-circuit comparator input is sampled into a fault flag each time a conversion starts. A remote result equal to the short-circuit code (0x80, the integer value -128) raises a separate flag. The serial register interface lives outside this block and is unaffected by standby.

The FSM has four states:
- `ST_IDLE` is standby. It moves to `ST_LAUNCH` on leaving standby, or on a one-shot request during software standby.
- `ST_LAUNCH` issues the start. It moves to `ST_CONVERT`, or to `ST_IDLE` on abort.
- `ST_CONVERT` waits for done. On done it moves to `ST_GAP` in normal mode. In one-shot mode it moves to `ST_LAUNCH` after the local channel and to `ST_IDLE` after the remote channel. On abort it moves to `ST_IDLE`.
- `ST_GAP` counts the interval and then moves to `ST_LAUNCH`. It moves to `ST_IDLE` on either standby.

Top module: `conv_seq_ctrl`

## Requirements
- R1: During and right after reset, `local_val`, `remote_val`, `fault_open` and `remote_short` are 0, and `adc_start` and `adc_stop` are low.
- R2: In normal mode (`stby_n`=1, `sw_stby`=0), conversions alternate between the local channel (`adc_chan`=0) and the remote channel (`adc_chan`=1). The first conversion after leaving standby is local.
- R3: In normal mode, after the cycle in which `adc_done` completes a conversion, the block spends exactly `interval` cycles (with `interval` >= 1) before the next `adc_start` cycle.
- R4: When `adc_done` is high in a conversion that is not aborted, `adc_result` is stored in `local_val` (`adc_chan`=0) or in `remote_val` (`adc_chan`=1). The stored value is visible in the next cycle.
- R5: Entering standby during a conversion raises `adc_stop` in that same cycle and abandons the conversion. An `adc_done` in that cycle or later leaves both value registers unchanged.
- R6: While `stby_n` is low, `adc_start` stays low and `oneshot_req` has no effect.
- R7: With `sw_stby`=1 and `stby_n`=1, no periodic conversion starts. A one-cycle `oneshot_req` converts local and then remote with no gap between them, and the block then returns to standby with no further starts.
- R8: A `oneshot_req` that arrives while a one-shot is in progress is ignored and causes no further conversion.
- R9: In every cycle in which `adc_start` is high, `open_fault` is captured into `fault_open`. The captured value is visible in the next cycle.
- R10: `remote_short` becomes 1 when a remote result equal to 0x80 is stored. It becomes 0 when any other remote result is stored. Local results do not change it.
- R11: `adc_start` is high for exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_n | input | 1 | Hardware standby, active low |
| sw_stby | input | 1 | Software standby bit |
| oneshot_req | input | 1 | One-cycle one-shot request pulse |
| interval | input | IVL_W (16) | Gap between conversions in cycles |
| open_fault | input | 1 | Open-circuit comparator output |
| adc_start | output | 1 | Start pulse to converter |
| adc_stop | output | 1 | Abort of a running conversion |
| adc_chan | output | 1 | Channel select: 0 local, 1 remote |
| adc_done | input | 1 | Converter finished |
| adc_result | input | RES_W (8) | Converter result byte |
| local_val | output | RES_W (8) | Stored local result |
| remote_val | output | RES_W (8) | Stored remote result |
| fault_open | output | 1 | Open-circuit fault status |
| remote_short | output | 1 | Remote short-circuit code seen |

## Verification
Several rules are checked on every cycle by assertions:
- the start pulse lasts one cycle;
- no start follows a cycle with hardware standby;
- the fault flag follows the comparator as sampled at each start;
- a value register changes only after a done outside hardware standby;
- the short flag follows each stored remote byte.

The bench scenarios are needed for rules that depend on ordering over many cycles:
- the local/remote alternation;
- the exact interval length;
- discarding a result that arrives with or after an abort;
- the difference between hardware and software standby for one-shots;
- rejection of a second one-shot request.

// File: rtl/conv_pkg.sv
package conv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GAP     = 2'd1,
        ST_LAUNCH  = 2'd2,
        ST_CONVERT = 2'd3
    } seq_state_t;

    typedef enum logic {
        CH_LOCAL  = 1'b0,
        CH_REMOTE = 1'b1
    } chan_t;
endpackage

// File: rtl/conv_gap_timer.sv
module conv_gap_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IVL_W-1:0] interval,
    output logic             expire
);
    localparam int CNT_W = IVL_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign expire  = run && (cnt_inc >= {1'b0, interval});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    // R3
    gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (cnt_q == '0));
endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
    import conv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stby_n,
    input  logic  sw_stby,
    input  logic  oneshot_req,
    input  logic  adc_done,
    input  logic  gap_expire,
    output logic  gap_run,
    output logic  adc_start,
    output logic  adc_stop,
    output chan_t chan,
    output logic  wr_en
);
    seq_state_t state_q, state_d;
    chan_t      chan_q, chan_d;
    logic       os_q, os_d;
    logic       hw_stby;
    logic       abort;
    logic       busy;

    assign hw_stby = !stby_n;
    assign abort   = hw_stby || (sw_stby && !os_q);
    assign busy    = (state_q == ST_LAUNCH) || (state_q == ST_CONVERT);

    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        os_d    = os_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!hw_stby) begin
                    if (!sw_stby) begin
                        state_d = ST_LAUNCH;
                        chan_d  = CH_LOCAL;
                        os_d    = 1'b0;
                    end else if (oneshot_req) begin
                        state_d = ST_LAUNCH;
                        chan_d  = CH_LOCAL;
                        os_d    = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (hw_stby || sw_stby) begin
                    state_d = ST_IDLE;
                end else if (gap_expire) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                if (abort) begin
                    state_d = ST_IDLE;
                    os_d    = 1'b0;
                end else begin
                    state_d = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (abort) begin
                    state_d = ST_IDLE;
                    os_d    = 1'b0;
                end else if (adc_done) begin
                    if (os_q) begin
                        if (chan_q == CH_LOCAL) begin
                            chan_d  = CH_REMOTE;
                            state_d = ST_LAUNCH;
                        end else begin
                            state_d = ST_IDLE;
                            os_d    = 1'b0;
                        end
                    end else begin
                        chan_d  = (chan_q == CH_LOCAL) ? CH_REMOTE : CH_LOCAL;
                        state_d = ST_GAP;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= CH_LOCAL;
            os_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
            os_q    <= os_d;
        end
    end

    always_comb begin
        adc_start = (state_q == ST_LAUNCH) && !abort;
        adc_stop  = busy && abort;
        wr_en     = (state_q == ST_CONVERT) && adc_done && !abort;
        gap_run   = (state_q == ST_GAP);
        chan      = chan_q;
    end

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R5
    stop_ends_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_stop |=> (state_q == ST_IDLE));
endmodule

// File: rtl/conv_results.sv
module conv_results
    import conv_pkg::*;
#(
    parameter int               RES_W      = 8,
    parameter logic [RES_W-1:0] SHORT_CODE = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  chan_t            chan,
    input  logic [RES_W-1:0] result,
    input  logic             launch,
    input  logic             open_fault,
    output logic [RES_W-1:0] local_val,
    output logic [RES_W-1:0] remote_val,
    output logic             fault_open,
    output logic             remote_short
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            local_val    <= '0;
            remote_val   <= '0;
            remote_short <= 1'b0;
        end else if (wr_en) begin
            if (chan == CH_LOCAL) begin
                local_val <= result;
            end else begin
                remote_val   <= result;
                remote_short <= (result == SHORT_CODE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_open <= 1'b0;
        end else if (launch) begin
            fault_open <= open_fault;
        end
    end

    // R10
    short_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chan == CH_LOCAL) |=> $stable(remote_short));
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_pkg::*;
#(
    parameter int               IVL_W      = 16,
    parameter int               RES_W      = 8,
    parameter logic [RES_W-1:0] SHORT_CODE = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_n,
    input  logic             sw_stby,
    input  logic             oneshot_req,
    input  logic [IVL_W-1:0] interval,
    input  logic             open_fault,
    output logic             adc_start,
    output logic             adc_stop,
    output logic             adc_chan,
    input  logic             adc_done,
    input  logic [RES_W-1:0] adc_result,
    output logic [RES_W-1:0] local_val,
    output logic [RES_W-1:0] remote_val,
    output logic             fault_open,
    output logic             remote_short
);
    logic  gap_run;
    logic  gap_expire;
    logic  wr_en;
    chan_t chan;

    conv_gap_timer #(.IVL_W(IVL_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gap_run),
        .interval (interval),
        .expire   (gap_expire)
    );

    conv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stby_n      (stby_n),
        .sw_stby     (sw_stby),
        .oneshot_req (oneshot_req),
        .adc_done    (adc_done),
        .gap_expire  (gap_expire),
        .gap_run     (gap_run),
        .adc_start   (adc_start),
        .adc_stop    (adc_stop),
        .chan        (chan),
        .wr_en       (wr_en)
    );

    conv_results #(.RES_W(RES_W), .SHORT_CODE(SHORT_CODE)) u_res (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .chan         (chan),
        .result       (adc_result),
        .launch       (adc_start),
        .open_fault   (open_fault),
        .local_val    (local_val),
        .remote_val   (remote_val),
        .fault_open   (fault_open),
        .remote_short (remote_short)
    );

    assign adc_chan = chan;

    // R4
    write_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(local_val) || !$stable(remote_val)) |-> ($past(adc_done) && $past(stby_n)));

    // R6
    hw_stby_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!stby_n) |-> !adc_start);

    // R9
    fault_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> (fault_open == $past(open_fault)));

    // R10
    short_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(remote_val) |-> (remote_short == (remote_val == SHORT_CODE)));
endmodule

// File: tb/tb_conv_seq_ctrl.sv
`timescale 1ns/100ps
module tb_conv_seq_ctrl;
    localparam int IVL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_n = 1'b1;
    logic        sw_stby = 1'b0;
    logic        oneshot_req = 1'b0;
    logic [15:0] interval = 16'(IVL);
    logic        open_fault = 1'b0;
    logic        adc_start, adc_stop, adc_chan;
    logic        adc_done = 1'b0;
    logic [7:0]  adc_result = 8'h00;
    logic [7:0]  local_val, remote_val;
    logic        fault_open, remote_short;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    conv_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .sw_stby(sw_stby),
        .oneshot_req(oneshot_req), .interval(interval), .open_fault(open_fault),
        .adc_start(adc_start), .adc_stop(adc_stop), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_result(adc_result),
        .local_val(local_val), .remote_val(remote_val),
        .fault_open(fault_open), .remote_short(remote_short)
    );

    // fields: local result, remote result, local fault, remote fault
    localparam logic [17:0] VEC [4] = '{
        {8'h19, 8'h2A, 1'b0, 1'b1},
        {8'h00, 8'h80, 1'b1, 1'b0},
        {8'h80, 8'h55, 1'b0, 1'b0},
        {8'h7F, 8'h80, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (!adc_start && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!adc_start) chk("watchdog wait for adc_start", 0, 1);
    endtask

    task automatic serve(input logic ch, input logic [7:0] res, input logic flt,
                         input int gap_exp);
        int n;
        open_fault = flt;
        wait_start(n);
        if (gap_exp >= 0) chk("R3 gap cycles", n, gap_exp);
        chk("R2 channel order", adc_chan, ch);
        @(negedge clk);
        chk("R9 fault capture", fault_open, flt);
        @(negedge clk);
        adc_done = 1'b1;
        adc_result = res;
        @(negedge clk);
        adc_done = 1'b0;
        if (ch) chk("R4 remote store", remote_val, res);
        else    chk("R4 local store", local_val, res);
    endtask

    task automatic no_start(input int cycles, input string tag);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (adc_start) seen++;
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        #(200000 * 5);
        chk("watchdog global", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        chk("R1 reset local_val", local_val, 0);
        chk("R1 reset remote_val", remote_val, 0);
        chk("R1 reset flags", {fault_open, remote_short}, 0);
        chk("R1 reset start/stop", {adc_start, adc_stop}, 0);
        rst_n = 1'b1;

        // normal-mode vector walk
        for (int i = 0; i < 4; i++) begin
            serve(1'b0, VEC[i][17:10], VEC[i][1], (i == 0) ? -1 : IVL);
            chk("R10 local leaves short flag", remote_short, (i == 0) ? 0 : (VEC[i-1][9:2] == 8'h80));
            serve(1'b1, VEC[i][9:2], VEC[i][0], IVL);
            chk("R10 short flag", remote_short, VEC[i][9:2] == 8'h80);
        end

        // R5 abort while converting, done afterwards
        keep = local_val;
        wait_start(n);
        @(negedge clk);
        stby_n = 1'b0;
        #1 chk("R5 adc_stop on entry", adc_stop, 1);
        @(negedge clk);
        adc_done = 1'b1; adc_result = 8'hEE;
        @(negedge clk);
        adc_done = 1'b0;
        chk("R5 late done ignored", local_val, keep);

        // R5 abort in the same cycle as done
        stby_n = 1'b1;
        wait_start(n);
        chk("R2 local first after standby", adc_chan, 0);
        @(negedge clk);
        @(negedge clk);
        adc_done = 1'b1; adc_result = 8'hDD; stby_n = 1'b0;
        @(negedge clk);
        adc_done = 1'b0;
        chk("R5 same-cycle done ignored", local_val, keep);

        // R6 hardware standby blocks one-shot
        sw_stby = 1'b1;
        @(negedge clk); oneshot_req = 1'b1;
        @(negedge clk); oneshot_req = 1'b0;
        no_start(20, "R6 no start in hw standby");
        chk("R6 values kept", {local_val, remote_val}, {keep, 8'h80});

        // R7 software standby: idle, then one-shot
        stby_n = 1'b1;
        no_start(20, "R7 no periodic start");
        oneshot_req = 1'b1;
        @(negedge clk); oneshot_req = 1'b0;
        serve(1'b0, 8'h33, 1'b1, -1);
        // R8 hold a request through the remote conversion
        oneshot_req = 1'b1;
        serve(1'b1, 8'h44, 1'b0, 0);
        oneshot_req = 1'b0;
        no_start(20, "R8 repeat request ignored, R7 back to standby");
        chk("R7 one-shot stored", {local_val, remote_val}, {8'h33, 8'h44});

        // R2 leaving software standby resumes with local
        sw_stby = 1'b0;
        serve(1'b0, 8'h21, 1'b0, -1);
        serve(1'b1, 8'h22, 1'b0, IVL);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule